// File: doc/BRIEF.md
# Descriptor Chain Walker for Scatter-Gather DMA

This block follows a linked list of 16-byte buffer descriptors held in system memory and turns each one into a single transfer request for a downstream data mover. A packet sequencer hands it the address of the first descriptor with a one-cycle `start` strobe. The walker then reads the descriptor one 32-bit word at a time. It checks the entry, presents the buffer address, byte count, direction, ordering hint and DMA mode to the data mover, and waits for that transfer to finish before it moves on.

Each descriptor carries its own link to the next entry, so the list may be scattered anywhere in the 32-bit address space. The walk ends in one of four ways:
- The transfer for an entry whose end flag is set completes. This is a clean finish.
- An entry with a zero length is found.
- The configured maximum number of entries is used up without an end flag.
- The data mover reports a failed transfer.

Every ending is reported with a one-cycle outcome pulse. A failure also carries a two-bit cause code.

Top module: `prd_walker`

## Requirements
- R1: After reset `busy`, `mem_rd`, `xfer_req`, `walk_done` and `walk_err` are low and `err_code` is 0.
- R2: A `start` pulse while idle loads `head_ptr` and raises `busy` in the next cycle. A `start` pulse while busy has no effect on the running walk. It changes no fetched address, no transfer and no outcome.
- R3: Each descriptor is read as four words at pointer+0, +4, +8 and +12, in that order. Each read is a one-cycle `mem_rd` pulse, and only one read is outstanding at a time. The next read is issued only after `mem_rvalid` has returned the previous word.
- R4: The transfer fields come from the descriptor words as follows:
  - `xfer_addr` is word 0, the full 32 bits.
  - `xfer_bytes` is word 1 shifted left by 3, so the length field counts 8-byte units and the result is 35 bits wide.
  - `xfer_out` is word 2 bit 5. It is set for a write to the device.
  - `xfer_order` is word 2 bit 4.
  - `xfer_mode` is word 2 bits 11:8.
  - Word 2 bits 3:0, bit 6, bits 15:12 and bits 31:16 are ignored.
- R5: `xfer_req` stays high with stable fields until `xfer_done` is sampled. No descriptor read is issued while a transfer is pending.
- R6: When the transfer of an entry with word 2 bit 7 (end) set completes without error, `walk_done` pulses for one cycle and no further read is made. The link word of that entry is not followed, and it may hold zero or any other value.
- R7: When an entry without the end flag completes, the next descriptor is fetched from the address held in that entry's word 3.
- R8: An entry whose length field is zero issues no transfer. The walk ends with `walk_err` and `err_code` = 1.
- R9: Let N be `MAX_DESC`. If the N-th entry completes without the end flag, the walk ends with `walk_err` and `err_code` = 2, and no further read is made. If the N-th entry carries the end flag, the walk finishes normally.
- R10: If `xfer_err` is high when `xfer_done` is sampled, the walk ends with `walk_err` and `err_code` = 3. This holds even when the entry carries the end flag.
- R11: `walk_done` and `walk_err` are one-cycle pulses and are never high together. `err_code` holds the cause of the last walk until the next accepted `start`, and it is 0 after a clean finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `head_ptr` |
| head_ptr | input | 32 | Address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| mem_rd | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request, held until done |
| xfer_addr | output | 32 | Buffer address |
| xfer_bytes | output | 35 | Transfer size in bytes |
| xfer_out | output | 1 | 1 = write to the device, 0 = read from it |
| xfer_order | output | 1 | Ordering hint from the flags byte |
| xfer_mode | output | 4 | DMA transfer mode |
| xfer_done | input | 1 | Data mover finished the current transfer |
| xfer_err | input | 1 | Qualifies `xfer_done` as failed |
| walk_done | output | 1 | Walk finished cleanly (pulse) |
| walk_err | output | 1 | Walk aborted (pulse) |
| err_code | output | 2 | Abort cause: 1 zero length, 2 chain too long, 3 bus error |

## Verification
Two pairs of functions can resolve in the same completion cycle.

The first pair is the clean end of a chain and a bus error. The bench places a transfer failure on the very entry that carries the end flag, so `xfer_done`, `xfer_err` and the end flag are all live in one cycle. The case is judged correct only if `walk_err` with cause 3 appears and `walk_done` stays low.

The second pair is the end flag and the chain-length limit. The bench builds a chain whose end flag sits exactly on entry `MAX_DESC`, and it must finish cleanly. A chain one entry longer must stop with cause 2 after exactly `MAX_DESC` transfers and 4·`MAX_DESC` reads.

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int MAX_DESC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] head_ptr,
  output logic        busy,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        xfer_req,
  output logic [31:0] xfer_addr,
  output logic [34:0] xfer_bytes,
  output logic        xfer_out,
  output logic        xfer_order,
  output logic [3:0]  xfer_mode,
  input  logic        xfer_done,
  input  logic        xfer_err,
  output logic        walk_done,
  output logic        walk_err,
  output logic [1:0]  err_code
);

  localparam int CW = $clog2(MAX_DESC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_DESC);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_XFER} state_t;

  state_t        st;
  logic [31:0]   cur_ptr;
  logic [31:0]   d_addr;
  logic [31:0]   d_len;
  logic [31:0]   d_link;
  logic          d_end, d_out, d_ord;
  logic [3:0]    d_mode;
  logic [1:0]    widx;
  logic [CW-1:0] ndesc;

  assign busy       = (st != S_IDLE);
  assign mem_rd     = (st == S_FETCH);
  assign mem_addr   = cur_ptr + {28'd0, widx, 2'b00};
  assign xfer_req   = (st == S_XFER);
  assign xfer_addr  = d_addr;
  assign xfer_bytes = {d_len, 3'b000};
  assign xfer_out   = d_out;
  assign xfer_order = d_ord;
  assign xfer_mode  = d_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_ptr   <= '0;
      d_addr    <= '0;
      d_len     <= '0;
      d_link    <= '0;
      d_end     <= 1'b0;
      d_out     <= 1'b0;
      d_ord     <= 1'b0;
      d_mode    <= '0;
      widx      <= '0;
      ndesc     <= '0;
      walk_done <= 1'b0;
      walk_err  <= 1'b0;
      err_code  <= 2'd0;
    end else begin
      walk_done <= 1'b0;
      walk_err  <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          cur_ptr  <= head_ptr;
          widx     <= '0;
          ndesc    <= '0;
          err_code <= 2'd0;
          st       <= S_FETCH;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          unique case (widx)
            2'd0: d_addr <= mem_rdata;
            2'd1: d_len  <= mem_rdata;
            2'd2: begin
              d_ord  <= mem_rdata[4];
              d_out  <= mem_rdata[5];
              d_end  <= mem_rdata[7];
              d_mode <= mem_rdata[11:8];
            end
            default: d_link <= mem_rdata;
          endcase
          widx <= widx + 2'd1;
          if (widx == 2'd3) begin
            ndesc <= ndesc + 1'b1;
            st    <= S_CHECK;
          end else begin
            st <= S_FETCH;
          end
        end
        S_CHECK: if (d_len == 32'd0) begin
          walk_err <= 1'b1;
          err_code <= 2'd1;
          st       <= S_IDLE;
        end else begin
          st <= S_XFER;
        end
        S_XFER: if (xfer_done) begin
          if (xfer_err) begin
            walk_err <= 1'b1;
            err_code <= 2'd3;
            st       <= S_IDLE;
          end else if (d_end) begin
            walk_done <= 1'b1;
            st        <= S_IDLE;
          end else if (ndesc == LIMIT) begin
            walk_err <= 1'b1;
            err_code <= 2'd2;
            st       <= S_IDLE;
          end else begin
            cur_ptr <= d_link;
            st      <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr) && $stable(xfer_bytes) && $stable(xfer_mode)); // R5
  AST_NO_READ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_req && mem_rd)); // R5
  AST_NONZERO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_bytes != 35'd0); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> $past(xfer_req && xfer_done && !xfer_err)); // R6
  AST_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done && xfer_err |=> walk_err && err_code == 2'd3); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ndesc <= LIMIT); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_err)); // R11

endmodule

// File: tb/prd_walker_test.sv
module prd_walker_test;
  localparam int MAXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] head_ptr = '0;
  logic        busy, mem_rd, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        xfer_req, xfer_out, xfer_order, xfer_done = 1'b0, xfer_err = 1'b0;
  logic [31:0] xfer_addr;
  logic [34:0] xfer_bytes;
  logic [3:0]  xfer_mode;
  logic        walk_done, walk_err;
  logic [1:0]  err_code;

  prd_walker #(.MAX_DESC(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes), .xfer_out(xfer_out),
    .xfer_order(xfer_order), .xfer_mode(xfer_mode), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .walk_done(walk_done), .walk_err(walk_err), .err_code(err_code));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:255];

  int          exp_n, exp_rd, exp_out;
  logic [31:0] exp_addr [0:15];
  logic [34:0] exp_bytes [0:15];
  logic [5:0]  exp_bits [0:15];
  logic [31:0] exp_rda [0:63];

  int          obs_n = 0, rd_cnt = 0, inj_idx = -1;
  logic [31:0] obs_addr [0:15];
  logic [34:0] obs_bytes [0:15];
  logic [5:0]  obs_bits [0:15];
  logic [31:0] obs_rda [0:63];

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  bit rd_pend = 0;
  int rd_dly = 0;
  logic [31:0] rd_word;
  always @(negedge clk) begin
    mem_rvalid <= 1'b0;
    if (rd_pend) begin
      if (rd_dly == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd_word;
        rd_pend = 0;
      end else rd_dly--;
    end
    if (mem_rd) begin
      rd_pend = 1;
      rd_dly  = $urandom % 3;
      rd_word = mem[mem_addr[9:2]];
      if (rd_cnt < 64) obs_rda[rd_cnt] = mem_addr;
      rd_cnt++;
    end
  end

  bit mv_busy = 0;
  int mv_dly = 0;
  always @(negedge clk) begin
    xfer_done <= 1'b0;
    xfer_err  <= 1'b0;
    if (mv_busy) begin
      if (mv_dly == 0) begin
        xfer_done <= 1'b1;
        xfer_err  <= (obs_n - 1 == inj_idx);
        mv_busy = 0;
      end else mv_dly--;
    end else if (xfer_req) begin
      if (obs_n < 16) begin
        obs_addr[obs_n]  = xfer_addr;
        obs_bytes[obs_n] = xfer_bytes;
        obs_bits[obs_n]  = {xfer_out, xfer_order, xfer_mode};
      end
      obs_n++;
      mv_busy = 1;
      mv_dly  = $urandom % 4;
    end
  end

  function automatic logic [31:0] slot_ptr(input int s);
    return 32'(s % 64) << 4;
  endfunction

  task automatic put_desc(input int s, input logic [31:0] a, input logic [31:0] l,
                          input logic [7:0] fl, input logic [3:0] md, input logic [31:0] nx);
    int w = (s % 64) * 4;
    mem[w]   = a;
    mem[w+1] = l;
    mem[w+2] = {$urandom % 65536 > 0 ? 16'($urandom) : 16'h0, 4'($urandom), md, fl};
    mem[w+3] = nx;
  endtask

  task automatic make_chain(input int s0, input int n, input int zpos, input bit zero_link,
                            output logic [31:0] head);
    for (int k = 0; k < n; k++) begin
      int s = s0 + k * 7;
      logic [31:0] l = $urandom;
      logic [7:0] fl = 8'($urandom) & 8'h7f;
      if (l == 0) l = 1;
      if (k == zpos) l = 0;
      if (k == n - 1) fl[7] = 1'b1;
      put_desc(s, $urandom, l, fl, 4'($urandom),
               (k == n - 1) ? (zero_link ? 32'h0 : $urandom) : slot_ptr(s + 7));
    end
    head = slot_ptr(s0);
  endtask

  task automatic model(input logic [31:0] head, input int inj);
    logic [31:0] p = head;
    exp_n = 0; exp_rd = 0;
    forever begin
      int w = p[9:2];
      for (int j = 0; j < 4; j++) begin exp_rda[exp_rd] = p + 32'(4 * j); exp_rd++; end
      if (mem[w+1] == 0) begin exp_out = 1; break; end
      exp_addr[exp_n]  = mem[w];
      exp_bytes[exp_n] = {mem[w+1], 3'b000};
      exp_bits[exp_n]  = {mem[w+2][5], mem[w+2][4], mem[w+2][11:8]};
      exp_n++;
      if (inj == exp_n - 1) begin exp_out = 3; break; end
      if (mem[w+2][7]) begin exp_out = 0; break; end
      if (exp_rd / 4 == MAXD) begin exp_out = 2; break; end
      p = mem[w+3];
    end
  endtask

  task automatic run_walk(input logic [31:0] head, input int inj, input bit poke, input string tag);
    int t = 0;
    model(head, inj);
    obs_n = 0; rd_cnt = 0; inj_idx = inj;
    @(negedge clk); start = 1'b1; head_ptr = head;
    @(negedge clk); start = 1'b0; head_ptr = $urandom;
    check(busy === 1'b1, {"R2 busy after start ", tag}, busy, 1);
    while (!(walk_done || walk_err) && t < 5000) begin
      start = (poke && (t == 3 || t == 9));
      head_ptr = slot_ptr(40);
      @(negedge clk); t++;
    end
    start = 1'b0;
    check(walk_done === (exp_out == 0), {"R6 walk_done ", tag}, walk_done, exp_out == 0);
    check(walk_err === (exp_out != 0), {"R11 walk_err ", tag}, walk_err, exp_out != 0);
    check(err_code === 2'(exp_out), {"R8 R9 R10 err_code ", tag}, err_code, exp_out);
    @(negedge clk);
    check(!walk_done && !walk_err && !busy, {"R11 single pulse ", tag}, {walk_done, walk_err, busy}, 0);
    check(err_code === 2'(exp_out), {"R11 code held ", tag}, err_code, exp_out);
    check(obs_n == exp_n, {"R5 transfer count ", tag}, obs_n, exp_n);
    check(rd_cnt == exp_rd, {"R3 read count ", tag}, rd_cnt, exp_rd);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      check(obs_addr[i] === exp_addr[i], {"R4 addr ", tag}, obs_addr[i], exp_addr[i]);
      check(obs_bytes[i] === exp_bytes[i], {"R4 bytes ", tag}, obs_bytes[i], exp_bytes[i]);
      check(obs_bits[i] === exp_bits[i], {"R4 dir/order/mode ", tag}, obs_bits[i], exp_bits[i]);
    end
    for (int i = 0; i < exp_rd && i < rd_cnt && i < 64; i++)
      check(obs_rda[i] === exp_rda[i], {"R7 read address ", tag}, obs_rda[i], exp_rda[i]);
  endtask

  initial begin
    logic [31:0] h;
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !xfer_req && !walk_done && !walk_err && err_code == 0,
          "R1 reset state", {busy, mem_rd, xfer_req, walk_done, walk_err, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    put_desc(0, 32'hFFFF_FFF8, 32'h1, 8'h80, 4'h6, 32'h0);
    run_walk(slot_ptr(0), -1, 0, "single end R6");
    put_desc(1, 32'h0000_1000, 32'hFFFF_FFFF, 8'hA0, 4'hF, 32'hDEAD_BEE0);
    run_walk(slot_ptr(1), -1, 0, "max length R4");
    make_chain(2, 3, -1, 1, h);  run_walk(h, -1, 0, "three R7");
    make_chain(3, 4, 1, 0, h);   run_walk(h, -1, 0, "zero len R8");
    make_chain(4, 1, 0, 0, h);   run_walk(h, -1, 0, "zero first R8");
    make_chain(5, MAXD, -1, 0, h);     run_walk(h, -1, 0, "end at limit R9");
    make_chain(6, MAXD + 1, -1, 0, h); run_walk(h, -1, 0, "over limit R9");
    make_chain(8, 3, -1, 0, h);  run_walk(h, 2, 0, "bus err on last R10");
    make_chain(9, 5, -1, 0, h);  run_walk(h, 1, 0, "bus err mid R10");
    make_chain(40, 2, -1, 0, h);
    make_chain(10, 4, -1, 0, h); run_walk(h, -1, 1, "start while busy R2");

    for (int r = 0; r < 60; r++) begin
      int n = 1 + $urandom % 10;
      int z = ($urandom % 5 == 0) ? int'($urandom % n) : -1;
      int e = ($urandom % 5 == 0) ? int'($urandom % n) : -1;
      make_chain(int'($urandom % 64), n, z, $urandom % 2, h);
      run_walk(h, e, $urandom % 4 == 0, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule